// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel word from a host into an asynchronous serial frame on a single output line. The frame layout can be set at run time: the data length (5 to 9 bits), the parity mode (none, even or odd) and the stop-bit count (one or two). The bit period comes from a 12-bit divisor and a speed-mode select. The divisor first makes an internal sample-rate tick. Every 16 sample ticks (normal mode), or every 8 sample ticks (double-speed mode), make one bit period.

The host side has one holding register. The host writes a word with a one-cycle strobe when the buffer-empty flag is high. If the line is idle, the word moves into the shifter on the next cycle and its start bit begins. If a frame is in progress, the word waits in the holding register. It goes out immediately after the current frame's last stop bit, with no idle time between the frames. A separate transmit-complete flag shows that the line has gone idle and that nothing is waiting to be sent.

Top module: `serial_frame_tx`

## Requirements
- R1: Reset state. After a synchronous active-low reset, `txd` is 1, `buf_empty` is 1 and `tx_done` is 0. Whenever no frame is being shifted, `txd` stays at 1.
- R2: Bit period. Every bit of a frame lasts exactly N clock cycles. N = 16×(`cfg_divisor`+1) when `cfg_double` is 0, and N = 8×(`cfg_divisor`+1) when `cfg_double` is 1.
- R3: Frame order and data length.
  - A frame starts with one 0 start bit, followed by the data bits, least significant bit first.
  - `cfg_data_len` gives the number of data bits. Codes below 5 act as 5 and codes above 9 act as 9.
- R4: Parity encoding.
  - `cfg_parity` 2'b00 and 2'b11 send no parity bit. 2'b01 sends even parity and 2'b10 sends odd parity.
  - The parity bit comes right after the last data bit.
  - With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number of ones.
- R5: Stop bits. A frame ends with one stop bit of value 1 when `cfg_two_stop` is 0, and with two stop bits when it is 1.
- R6: Write acceptance.
  - A write (`wr_en` high while `buf_empty` is 1) makes `buf_empty` 0 one cycle later.
  - If the line is idle, `txd` goes low one cycle after that, and at the same time `buf_empty` returns to 1.
- R7: Writes while full are dropped. A write made while `buf_empty` is 0 has no effect, and that word is never sent.
- R8: Back-to-back frames. A word held in the holding register during a frame starts its start bit in the cycle right after the last stop bit of the current frame. There is no idle cycle between the frames, and `tx_done` stays 0.
- R9: Transmit-complete flag. `tx_done` becomes 1 when a frame ends and the holding register is empty. It returns to 0 in the cycle after the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_divisor | input | 12 | Sample-rate divisor; the sample tick rate is clk/(value+1) |
| cfg_double | input | 1 | 1 selects 8 sample ticks per bit, 0 selects 16 |
| cfg_data_len | input | 4 | Number of data bits, 5 to 9 (clamped) |
| cfg_parity | input | 2 | 00/11 none, 01 even, 10 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| wr_en | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | 9 | Word to send; only the low `cfg_data_len` bits are used |
| txd | output | 1 | Serial output line, idle high |
| buf_empty | output | 1 | Holding register is free for a write |
| tx_done | output | 1 | Line is idle and nothing is waiting to be sent |

## Verification
The assertions assume the following about the inputs:
- The configuration inputs stay unchanged while a frame is shifting.
- The divisor is never lowered below the prescaler count while a frame is in progress.

The stimulus keeps to these rules in two ways:
- It changes the configuration only at the negative edge on which a write is made into an idle transmitter.
- Each frame's timing is checked against that frame's own settings.

The stimulus does write while the buffer is full, on purpose, to show that such writes are dropped. Frames are checked at the first and at the last cycle of every bit, which also pins the exact bit period.

// File: rtl/sftx_pkg.sv
// Shared types for the serial frame transmitter.
// Assumes nothing beyond a two-bit parity selector from the host.
package sftx_pkg;
    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_RSVD = 2'b11
    } par_mode_e;
endpackage

// File: rtl/sftx_baud_gen.sv
// Bit-period tick generator: a prescaler makes a sample tick every
// (divisor+1) cycles, and an oversample counter makes one bit tick every
// 16 or 8 sample ticks. Counters are held at zero while run is low, so a
// frame starting from idle always gets a full first bit.
// Assumes divisor is stable while run is high.
module sftx_baud_gen #(
    parameter int DIV_W   = 12,
    parameter int OS_NORM = 16,
    parameter int OS_FAST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    input  logic             fast,
    output logic             baud_tick
);
    localparam int OS_W = $clog2(OS_NORM);

    logic [DIV_W-1:0] pre_cnt;
    logic [OS_W-1:0]  os_cnt;
    logic             sample_tick;
    logic             os_at_last;

    // Decode the end of a prescaler period and the end of a bit period.
    always_comb begin
        sample_tick = run && (pre_cnt == divisor);
        os_at_last  = fast ? (os_cnt == OS_W'(OS_FAST - 1))
                           : (os_cnt == OS_W'(OS_NORM - 1));
        baud_tick   = sample_tick && os_at_last;
    end

    // Advance the prescaler and the oversample counter while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            os_cnt  <= '0;
        end else begin
            pre_cnt <= sample_tick ? '0 : pre_cnt + 1'b1;
            if (sample_tick) begin
                os_cnt <= os_at_last ? '0 : os_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sftx_frame_pack.sv
// Combinational frame builder. Bit 0 is the start bit, the data follows
// LSB first, then the optional parity bit; every position above these is 1,
// so the stop bits come out of the fill. Also returns the bit count.
// Assumes len_code is any value; it is clamped to DATA_MIN..DATA_MAX.
module sftx_frame_pack #(
    parameter int DATA_MIN  = 5,
    parameter int DATA_MAX  = 9,
    parameter int FRAME_MAX = DATA_MAX + 4,
    parameter int LEN_W     = $clog2(DATA_MAX + 1),
    parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
    input  logic [DATA_MAX-1:0]  data,
    input  logic [LEN_W-1:0]     len_code,
    input  logic [1:0]           par_sel,
    input  logic                 two_stop,
    output logic [FRAME_MAX-1:0] frame,
    output logic [CNT_W-1:0]     bit_total
);
    import sftx_pkg::*;

    par_mode_e           mode;
    logic [LEN_W-1:0]    eff_len;
    logic [DATA_MAX-1:0] masked;
    logic                par_on;
    logic                par_bit;

    // Clamp the length, mask the data and work out the parity bit.
    always_comb begin
        mode = par_mode_e'(par_sel);
        if (len_code < LEN_W'(DATA_MIN))       eff_len = LEN_W'(DATA_MIN);
        else if (len_code > LEN_W'(DATA_MAX))  eff_len = LEN_W'(DATA_MAX);
        else                                   eff_len = len_code;
        for (int i = 0; i < DATA_MAX; i++) begin
            masked[i] = data[i] && (i < int'(eff_len));
        end
        par_on  = (mode == PAR_EVEN) || (mode == PAR_ODD);
        par_bit = (^masked) ^ (mode == PAR_ODD);
    end

    // Place the start, data and parity bits over an all-ones background.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < int'(eff_len)) frame[i + 1] = data[i];
        end
        for (int i = 1; i < FRAME_MAX; i++) begin
            if (par_on && (i == int'(eff_len) + 1)) frame[i] = par_bit;
        end
        bit_total = CNT_W'(eff_len) + CNT_W'(2) + CNT_W'(par_on) + CNT_W'(two_stop);
    end
endmodule

// File: rtl/sftx_shifter.sv
// Frame shifter: loads a prepared frame and shifts it out LSB first, one
// position per bit tick, filling with ones so the line rests high.
// Assumes load and a bit tick are meant together only on the last bit,
// where load wins and the next frame starts without a gap.
module sftx_shifter #(
    parameter int FRAME_MAX = 13,
    parameter int CNT_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [FRAME_MAX-1:0] frame,
    input  logic [CNT_W-1:0]     bit_total,
    input  logic                 baud_tick,
    output logic                 busy,
    output logic                 last_bit,
    output logic                 txd
);
    logic [FRAME_MAX-1:0] shreg;
    logic [CNT_W-1:0]     bits_left;

    // Flag the final bit of the frame being shifted.
    always_comb begin
        last_bit = busy && (bits_left == CNT_W'(1));
        txd      = shreg[0];
    end

    // Load a frame, shift on each bit tick, return to idle after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '1;
            bits_left <= '0;
            busy      <= 1'b0;
        end else if (load) begin
            shreg     <= frame;
            bits_left <= bit_total;
            busy      <= 1'b1;
        end else if (busy && baud_tick) begin
            if (last_bit) begin
                shreg     <= '1;
                bits_left <= '0;
                busy      <= 1'b0;
            end else begin
                shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
                bits_left <= bits_left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_frame_tx.sv
// Configurable asynchronous serial transmitter: a one-word holding
// register feeds a frame shifter that is timed by a divisor-based bit
// tick generator. Reports buffer-empty and transmit-complete.
// Assumes the cfg_* inputs are held steady while a frame is shifting.
module serial_frame_tx #(
    parameter int DIV_W    = 12,
    parameter int DATA_MIN = 5,
    parameter int DATA_MAX = 9,
    parameter int OS_NORM  = 16,
    parameter int OS_FAST  = 8,
    localparam int FRAME_MAX = DATA_MAX + 4,
    localparam int LEN_W     = $clog2(DATA_MAX + 1),
    localparam int CNT_W     = $clog2(FRAME_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    cfg_divisor,
    input  logic                cfg_double,
    input  logic [LEN_W-1:0]    cfg_data_len,
    input  logic [1:0]          cfg_parity,
    input  logic                cfg_two_stop,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wr_data,
    output logic                txd,
    output logic                buf_empty,
    output logic                tx_done
);
    logic [DATA_MAX-1:0]  hold_data;
    logic                 hold_full;
    logic                 done_q;
    logic                 busy;
    logic                 last_bit;
    logic                 baud_tick;
    logic                 wr_accept;
    logic                 load;
    logic                 end_idle;
    logic [FRAME_MAX-1:0] frame;
    logic [CNT_W-1:0]     bit_total;

    // Decide when a write is taken, when the shifter loads, and idle ends.
    always_comb begin
        wr_accept = wr_en && !hold_full;
        load      = hold_full && (!busy || (baud_tick && last_bit));
        end_idle  = baud_tick && last_bit && !hold_full;
        buf_empty = !hold_full;
        tx_done   = done_q;
    end

    // Holding register: fill on an accepted write, empty on a shifter load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (wr_accept) begin
            hold_data <= wr_data;
            hold_full <= 1'b1;
        end else if (load) begin
            hold_full <= 1'b0;
        end
    end

    // Transmit-complete flag: set when the line goes idle, clear on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)          done_q <= 1'b0;
        else if (wr_accept)  done_q <= 1'b0;
        else if (end_idle)   done_q <= 1'b1;
    end

    sftx_baud_gen #(
        .DIV_W   (DIV_W),
        .OS_NORM (OS_NORM),
        .OS_FAST (OS_FAST)
    ) baud_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .divisor   (cfg_divisor),
        .fast      (cfg_double),
        .baud_tick (baud_tick)
    );

    sftx_frame_pack #(
        .DATA_MIN  (DATA_MIN),
        .DATA_MAX  (DATA_MAX),
        .FRAME_MAX (FRAME_MAX),
        .LEN_W     (LEN_W),
        .CNT_W     (CNT_W)
    ) pack_i (
        .data      (hold_data),
        .len_code  (cfg_data_len),
        .par_sel   (cfg_parity),
        .two_stop  (cfg_two_stop),
        .frame     (frame),
        .bit_total (bit_total)
    );

    sftx_shifter #(
        .FRAME_MAX (FRAME_MAX),
        .CNT_W     (CNT_W)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .frame     (frame),
        .bit_total (bit_total),
        .baud_tick (baud_tick),
        .busy      (busy),
        .last_bit  (last_bit),
        .txd       (txd)
    );
endmodule

// File: rtl/sftx_checker.sv
// Protocol checker for serial_frame_tx, attached by bind. Relates the
// host flags, the line and the shifter's busy state over time.
// Assumes cfg_* inputs are steady while a frame shifts.
module sftx_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic txd,
    input logic buf_empty,
    input logic tx_done,
    input logic busy
);
    // R1: the line rests high whenever no frame is shifting
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R6: an accepted write occupies the holding register next cycle
    a_r6_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_empty) |=> !buf_empty);

    // R6: a waiting word with an idle shifter starts its start bit next cycle
    a_r6_start_next: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !buf_empty) |=> (busy && !txd && buf_empty));

    // R9: transmit-complete implies an idle line and an empty buffer
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (txd && buf_empty && !busy));

    // R9: an accepted write clears transmit-complete
    a_r9_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_empty) |=> !tx_done);

    // R9: a frame that ends into idle sets transmit-complete unless a write came in
    a_r9_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (txd && (tx_done || $past(wr_en))));
endmodule

bind serial_frame_tx sftx_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .txd       (txd),
    .buf_empty (buf_empty),
    .tx_done   (tx_done),
    .busy      (busy)
);

// File: tb/serial_frame_tx_tb_top.sv
`timescale 1ns/1ps
// Sweep bench: every data length, parity mode and stop count at the
// fastest divisor, plus several divisor and speed settings. Expected
// bits and periods are computed arithmetically from the requirements.
module serial_frame_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] cfg_divisor;
    logic        cfg_double;
    logic [3:0]  cfg_data_len;
    logic [1:0]  cfg_parity;
    logic        cfg_two_stop;
    logic        wr_en;
    logic [8:0]  wr_data;
    logic        txd;
    logic        buf_empty;
    logic        tx_done;

    int vec_cnt = 0;
    int err_cnt = 0;
    int t       = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    serial_frame_tx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_divisor  (cfg_divisor),
        .cfg_double   (cfg_double),
        .cfg_data_len (cfg_data_len),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .txd          (txd),
        .buf_empty    (buf_empty),
        .tx_done      (tx_done)
    );

    task automatic chk(string req, int act, int exp);
        vec_cnt++;
        if (act != exp) begin
            err_cnt++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic int eff_len(int code);
        if (code < 5) return 5;
        if (code > 9) return 9;
        return code;
    endfunction

    function automatic bit par_on(int par);
        return (par == 1) || (par == 2);
    endfunction

    function automatic int total_bits(int len, int par, int stop2);
        return 1 + len + (par_on(par) ? 1 : 0) + (stop2 ? 2 : 1);
    endfunction

    function automatic int exp_bit(int data, int len, int par, int k);
        int ones = 0;
        if (k == 0) return 0;
        if (k <= len) return (data >> (k - 1)) & 1;
        if (par_on(par) && k == len + 1) begin
            for (int i = 0; i < len; i++) ones += (data >> i) & 1;
            return (ones % 2) ^ ((par == 2) ? 1 : 0);
        end
        return 1;
    endfunction

    function automatic string bit_tag(int len, int par, int k);
        if (k == 0) return "R3 start bit";
        if (k <= len) return "R3 data bit";
        if (par_on(par) && k == len + 1) return "R4 parity bit";
        return "R5 stop bit";
    endfunction

    // Move forward to a negedge offset relative to the current start bit.
    task automatic adv(int target);
        if (target > t) repeat (target - t) @(negedge clk);
        t = target;
    endtask

    // Check each bit at its first and last cycle (R2 period, R3..R5 content).
    task automatic check_frame(int data, int len, int par, int n);
        int tot = total_bits(len, par, 0);
        for (int k = 0; k < tot + 8; k++) begin
            if (k >= total_bits(len, par, stop_sel)) break;
            if (k * n >= t) begin
                adv(k * n);
                chk({bit_tag(len, par, k), " (R2 bit begin)"}, int'(txd), exp_bit(data, len, par, k));
            end
            adv(k * n + n - 1);
            chk({bit_tag(len, par, k), " (R2 bit end)"}, int'(txd), exp_bit(data, len, par, k));
        end
    endtask

    int stop_sel = 0;

    task automatic set_cfg(int div, int dbl, int lcode, int par, int stop2);
        cfg_divisor  = 12'(div);
        cfg_double   = dbl[0];
        cfg_data_len = 4'(lcode);
        cfg_parity   = 2'(par);
        cfg_two_stop = stop2[0];
        stop_sel     = stop2;
    endtask

    // Write one word into an idle transmitter and wait for its start bit (R6).
    task automatic start_word(int data);
        wr_en   = 1'b1;
        wr_data = 9'(data);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 buffer occupied after write", int'(buf_empty), 0);
        chk("R9 done cleared by write", int'(tx_done), 0);
        chk("R6 line still high before load", int'(txd), 1);
        @(negedge clk);
        chk("R6 start bit after load", int'(txd), 0);
        chk("R6 buffer free after load", int'(buf_empty), 1);
        t = 0;
    endtask

    task automatic single(int data, int div, int dbl, int lcode, int par, int stop2);
        int n   = (div + 1) * (dbl ? 8 : 16);
        int len = eff_len(lcode);
        int tot = total_bits(len, par, stop2);
        set_cfg(div, dbl, lcode, par, stop2);
        start_word(data);
        check_frame(data, len, par, n);
        adv(tot * n);
        chk("R9 done after frame", int'(tx_done), 1);
        chk("R1 line idle after frame", int'(txd), 1);
        @(negedge clk);
    endtask

    // Two words queued back to back plus one dropped write (R7, R8).
    task automatic queued(int a, int b, int c, int div, int dbl, int lcode, int par, int stop2);
        int n   = (div + 1) * (dbl ? 8 : 16);
        int len = eff_len(lcode);
        int tot = total_bits(len, par, stop2);
        set_cfg(div, dbl, lcode, par, stop2);
        start_word(a);
        wr_en   = 1'b1;
        wr_data = 9'(b);
        adv(1);
        chk("R8 second word held", int'(buf_empty), 0);
        wr_data = 9'(c);
        adv(2);
        wr_en = 1'b0;
        chk("R7 buffer still full after dropped write", int'(buf_empty), 0);
        check_frame(a, len, par, n);
        adv(tot * n);
        chk("R8 next start bit without gap", int'(txd), 0);
        chk("R8 done stays low between frames", int'(tx_done), 0);
        chk("R8 buffer freed by reload", int'(buf_empty), 1);
        t = 0;
        check_frame(b, len, par, n);
        adv(tot * n);
        chk("R9 done after final frame", int'(tx_done), 1);
        adv(tot * n + 3 * n);
        chk("R7 dropped word never sent", int'(txd), 1);
        chk("R7 buffer empty at end", int'(buf_empty), 1);
        @(negedge clk);
    endtask

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        set_cfg(0, 0, 8, 0, 0);
        repeat (3) @(negedge clk);
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset buf_empty", int'(buf_empty), 1);
        chk("R1 reset tx_done", int'(tx_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle line after reset", int'(txd), 1);

        // R3 R4 R5: every length, parity mode and stop count at divisor 0
        for (int len = 5; len <= 9; len++)
            for (int par = 0; par <= 2; par++)
                for (int st = 0; st <= 1; st++)
                    single((len * 37 + par * 113 + st * 71 + 'h15A) & 'h1FF, 0, 0, len, par, st);

        // R4: reserved parity code sends no parity bit
        single('h0A5, 0, 0, 8, 3, 0);
        // R3: length codes outside the range clamp
        single('h1C3, 0, 0, 2, 1, 0);
        single('h1FF, 0, 1, 12, 2, 1);
        // R2: other divisors and double speed, data extremes
        single('h000, 1, 1, 8, 1, 1);
        single('h1FF, 2, 0, 9, 2, 0);
        single('h055, 3, 1, 7, 0, 0);
        single('h0AA, 1, 0, 6, 1, 1);
        // R7 R8: back-to-back with a dropped write
        queued('h03C, 'h0C3, 'h1FF, 1, 0, 7, 1, 1);
        queued('h1A5, 'h05A, 'h000, 0, 1, 9, 2, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vec_cnt++;
            err_cnt++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end
endmodule